// File: doc/BRIEF.md
# Receive Frame Class-of-Service Rule Matcher

This block assigns a class of service to each received frame. An upstream parser pulls one 32-bit operand per rule out of the frame and presents all of them together for one cycle with a valid strobe. A bank of eight programmable rules compares against these operands. Each rule has a 32-bit match word and a small control word. The control word holds an enable bit, a match-mode bit and a 4-bit class code. Of the enabled rules that hit, the lowest-numbered one sets the outgoing class.

The match word can be read in two ways. In masked mode, its upper half is an ignore-mask over the lower 16 bits, and only the operand's low half takes part in the compare. In full mode, all 32 bits of the word are compared with the whole operand and no bit is masked. When no rule hits, a programmable default class is used. A default of zero means the frame is dropped. The result appears one cycle after the strobe as a class, a drop flag and a one-cycle valid pulse. Software programs the bank through a simple write port and can read it back through a combinational read port.

Top module: `rx_class_engine`

## Requirements
- R1: After reset, every rule match word, every rule control word and the configuration word read as zero, and res_valid, res_class and res_drop are low.
- R2: Register select codes are 0 for a rule match word, 1 for a rule control word and 2 for the configuration word. A control word keeps only bit 31 (enable), bit 26 (full mode) and bits 3:0 (class code). The configuration word keeps only bits 7:3 (default class). All other bits read as zero.
- R3: With bit 26 clear (masked mode), a rule hits when the operand's bits 15:0 equal the word's bits 15:0 at every position where the word's bits 31:16 hold a 0. Operand bits 31:16 are ignored.
- R4: With bit 26 set (full mode), a rule hits only when all 32 operand bits equal the 32-bit match word.
- R5: A rule whose enable bit is clear never hits, whatever its word and operand.
- R6: When one or more enabled rules hit, the lowest-numbered of them wins, and res_class equals that rule's class code plus one (codes 0..15 give classes 1..16).
- R7: When no rule hits and the default class is nonzero, res_class equals the default class and res_drop is low.
- R8: When no rule hits and the default class is zero, res_drop is high and res_class is zero.
- R9: Each cycle with op_valid high produces exactly one res_valid pulse on the next cycle, with no gaps for back-to-back operands. While res_valid is low, res_class and res_drop are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Write target: 0 match word, 1 control word, 2 configuration |
| reg_wr_idx | input | 3 | Rule number for the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 2 | Read target, same coding as reg_wr_sel |
| reg_rd_idx | input | 3 | Rule number for the read |
| reg_rd_data | output | 32 | Combinational read data |
| op_valid | input | 1 | Operands valid strobe |
| op_data | input | 256 | Per-rule operands, rule n at bits 32n+31:32n |
| res_valid | output | 1 | One-cycle result strobe |
| res_class | output | 5 | Class of service, 1 highest priority |
| res_drop | output | 1 | Frame is to be discarded |

## Verification
The bench uses one operand whose low half matches a rule while its high half differs. It checks this operand in both modes. A design that ignored the mode bit, or that compared the upper half in masked mode, would give the wrong class for it. Two rules are set to hit at once. This exposes a priority encoder that lets the highest index win, and an off-by-one in the class code mapping, including the top code that must give class 16. A disabled rule is given a hitting operand. Zero and nonzero defaults are both applied on a miss, to catch a drop flag tied to the wrong condition. The bench also sends back-to-back strobes and checks the idle cycle after a result, which exposes a stretched or lost valid pulse.

// File: rtl/rxc_pkg.sv
// Package: shared constants and types for the receive class-of-service matcher.
// Assumes 32-bit rule words and a 5-bit class output.
package rxc_pkg;
    localparam int WORD_W        = 32;
    localparam int HALF_W        = 16;
    localparam int CLS_W         = 5;
    localparam int RCLS_W        = 4;
    localparam int CTRL_EN_BIT   = 31;
    localparam int CTRL_MODE_BIT = 26;
    localparam int CFG_DEF_LSB   = 3;

    typedef enum logic [1:0] {
        SEL_WORD = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic              full;
        logic [RCLS_W-1:0] cls;
    } rule_ctrl_t;
endpackage

// File: rtl/rxc_reg_bank.sv
// Module: rxc_reg_bank
// Holds the rule match words, the rule control words and the default class.
// Writes take effect on the clock edge. Reads are combinational. Unkept bits read zero.
// Assumes NUM_RULES is a power of two, so every index value addresses a rule.
module rxc_reg_bank
    import rxc_pkg::*;
#(
    parameter int NUM_RULES = 8,
    parameter int IDX_W     = $clog2(NUM_RULES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_sel,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic [1:0]                  rd_sel,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [WORD_W-1:0]           rd_data,
    output logic [NUM_RULES*WORD_W-1:0] rule_words,
    output rule_ctrl_t [NUM_RULES-1:0]  rule_ctrls,
    output logic [CLS_W-1:0]            dflt_cls
);
    logic [WORD_W-1:0] word_q [NUM_RULES];
    rule_ctrl_t        ctrl_q [NUM_RULES];
    reg_sel_e          wsel;
    reg_sel_e          rsel;

    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
        // Per-rule storage: load the word or the control fields on a write addressed to this rule.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= '0;
                ctrl_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                if (wsel == SEL_WORD) word_q[g] <= wr_data;
                if (wsel == SEL_CTRL) begin
                    ctrl_q[g].en   <= wr_data[CTRL_EN_BIT];
                    ctrl_q[g].full <= wr_data[CTRL_MODE_BIT];
                    ctrl_q[g].cls  <= wr_data[RCLS_W-1:0];
                end
            end
        end
        assign rule_words[g*WORD_W +: WORD_W] = word_q[g];
        assign rule_ctrls[g]                  = ctrl_q[g];
    end

    // Configuration storage: keep only the default class field.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dflt_cls <= '0;
        else if (wr_en && wsel == SEL_CFG)   dflt_cls <= wr_data[CFG_DEF_LSB +: CLS_W];
    end

    // Read multiplexer: place kept fields at their bit positions, zero elsewhere.
    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_WORD: rd_data = word_q[rd_idx];
            SEL_CTRL: begin
                rd_data[CTRL_EN_BIT]   = ctrl_q[rd_idx].en;
                rd_data[CTRL_MODE_BIT] = ctrl_q[rd_idx].full;
                rd_data[RCLS_W-1:0]    = ctrl_q[rd_idx].cls;
            end
            SEL_CFG:  rd_data[CFG_DEF_LSB +: CLS_W] = dflt_cls;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rxc_rule_match.sv
// Module: rxc_rule_match
// Compares one operand with one rule word. In masked mode the word's upper
// half is an ignore-mask over the low 16 bits. In full mode all 32 bits are compared.
// Purely combinational.
module rxc_rule_match
    import rxc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              en,
    input  logic              full,
    input  logic [WORD_W-1:0] operand,
    output logic              hit
);
    logic [HALF_W-1:0] care;
    logic              masked_eq;
    logic              full_eq;

    // Masked compare: only the bits the mask does not ignore take part.
    assign care      = ~word[WORD_W-1:HALF_W];
    assign masked_eq = (((operand[HALF_W-1:0] ^ word[HALF_W-1:0]) & care) == '0);
    // Full compare: the whole word is the value.
    assign full_eq   = (operand == word);
    assign hit       = en & (full ? full_eq : masked_eq);
endmodule

// File: rtl/rxc_prio_select.sv
// Module: rxc_prio_select
// Picks the lowest-numbered hitting rule and maps its 4-bit code to class code+1.
// Purely combinational.
module rxc_prio_select
    import rxc_pkg::*;
#(
    parameter int NUM_RULES = 8
) (
    input  logic [NUM_RULES-1:0]        hits,
    input  logic [NUM_RULES*RCLS_W-1:0] codes,
    output logic                        any_hit,
    output logic [CLS_W-1:0]            cls
);
    // Priority scan: walk from the highest index down so the lowest index is written last.
    always_comb begin
        any_hit = 1'b0;
        cls     = '0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                cls     = CLS_W'(codes[i*RCLS_W +: RCLS_W]) + CLS_W'(1);
            end
        end
    end
endmodule

// File: rtl/rx_class_engine.sv
// Module: rx_class_engine (top)
// Classifies a frame from per-rule operands one cycle after op_valid.
// Assumes the operands are stable during the op_valid cycle. A register write
// on the same edge as op_valid does not affect that classification.
module rx_class_engine
    import rxc_pkg::*;
#(
    parameter int NUM_RULES = 8,
    parameter int IDX_W     = $clog2(NUM_RULES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr_en,
    input  logic [1:0]                  reg_wr_sel,
    input  logic [IDX_W-1:0]            reg_wr_idx,
    input  logic [WORD_W-1:0]           reg_wr_data,
    input  logic [1:0]                  reg_rd_sel,
    input  logic [IDX_W-1:0]            reg_rd_idx,
    output logic [WORD_W-1:0]           reg_rd_data,
    input  logic                        op_valid,
    input  logic [NUM_RULES*WORD_W-1:0] op_data,
    output logic                        res_valid,
    output logic [CLS_W-1:0]            res_class,
    output logic                        res_drop
);
    logic [NUM_RULES*WORD_W-1:0] rule_words;
    rule_ctrl_t [NUM_RULES-1:0]  rule_ctrls;
    logic [CLS_W-1:0]            dflt_cls;
    logic [NUM_RULES-1:0]        hits;
    logic [NUM_RULES*RCLS_W-1:0] codes;
    logic                        any_hit;
    logic [CLS_W-1:0]            hit_cls;

    rxc_reg_bank #(.NUM_RULES(NUM_RULES), .IDX_W(IDX_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_sel     (reg_wr_sel),
        .wr_idx     (reg_wr_idx),
        .wr_data    (reg_wr_data),
        .rd_sel     (reg_rd_sel),
        .rd_idx     (reg_rd_idx),
        .rd_data    (reg_rd_data),
        .rule_words (rule_words),
        .rule_ctrls (rule_ctrls),
        .dflt_cls   (dflt_cls)
    );

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_match
        rxc_rule_match u_match (
            .word    (rule_words[g*WORD_W +: WORD_W]),
            .en      (rule_ctrls[g].en),
            .full    (rule_ctrls[g].full),
            .operand (op_data[g*WORD_W +: WORD_W]),
            .hit     (hits[g])
        );
        assign codes[g*RCLS_W +: RCLS_W] = rule_ctrls[g].cls;
    end

    rxc_prio_select #(.NUM_RULES(NUM_RULES)) u_prio (
        .hits    (hits),
        .codes   (codes),
        .any_hit (any_hit),
        .cls     (hit_cls)
    );

    // Result register: capture the class or the default, and flag a drop on a zero default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_class <= '0;
            res_drop  <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (!op_valid) begin
                res_class <= '0;
                res_drop  <= 1'b0;
            end else if (any_hit) begin
                res_class <= hit_cls;
                res_drop  <= 1'b0;
            end else begin
                res_class <= dflt_cls;
                res_drop  <= (dflt_cls == '0);
            end
        end
    end
endmodule

// File: rtl/rxc_checker.sv
// Module: rxc_checker
// Temporal properties of the matcher outputs, bound to the top module.
module rxc_checker
    import rxc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              res_valid,
    input logic [CLS_W-1:0]  res_class,
    input logic              res_drop,
    input logic [1:0]        reg_rd_sel,
    input logic [WORD_W-1:0] reg_rd_data
);
    logic past_ok;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_RES_FOLLOWS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_valid)) |-> res_valid); // R9
    AST_NO_SPURIOUS_RES: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(op_valid)) |-> !res_valid); // R9
    AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_class == '0 && !res_drop)); // R9
    AST_DROP_CLASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_drop |-> (res_valid && res_class == '0)); // R8
    AST_KEPT_CLASS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_drop) |-> (res_class != '0)); // R7
    AST_CFG_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_sel == 2'd2) |-> ((reg_rd_data & 32'hFFFF_FF07) == '0)); // R2
endmodule

bind rx_class_engine rxc_checker u_rxc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .res_valid   (res_valid),
    .res_class   (res_class),
    .res_drop    (res_drop),
    .reg_rd_sel  (reg_rd_sel),
    .reg_rd_data (reg_rd_data)
);

// File: tb/test_rx_class_engine.sv
// Directed bench for rx_class_engine: one task per scenario.
module test_rx_class_engine;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [1:0]   reg_wr_sel = '0;
    logic [2:0]   reg_wr_idx = '0;
    logic [31:0]  reg_wr_data = '0;
    logic [1:0]   reg_rd_sel = '0;
    logic [2:0]   reg_rd_idx = '0;
    logic [31:0]  reg_rd_data;
    logic         op_valid = 1'b0;
    logic [255:0] op_data = '0;
    logic         res_valid;
    logic [4:0]   res_class;
    logic         res_drop;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    rx_class_engine i_rx_class_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_idx(reg_wr_idx),
        .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_idx(reg_rd_idx),
        .reg_rd_data(reg_rd_data), .op_valid(op_valid), .op_data(op_data),
        .res_valid(res_valid), .res_class(res_class), .res_drop(res_drop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [2:0] idx, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_idx = idx; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] sel, input logic [2:0] idx,
                          input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_rd_sel = sel; reg_rd_idx = idx;
        #1 chk(req, reg_rd_data, exp);
    endtask

    task automatic all_ops(input logic [31:0] v);
        op_data = {8{v}};
    endtask

    task automatic classify(input logic [4:0] exp_cls, input logic exp_drop, input string req);
        @(negedge clk);
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        chk({req, " valid"}, {31'd0, res_valid}, 32'd1);
        chk({req, " class"}, {27'd0, res_class}, {27'd0, exp_cls});
        chk({req, " drop"},  {31'd0, res_drop},  {31'd0, exp_drop});
    endtask

    task automatic t_reset;
        chk("R1 res_valid", {31'd0, res_valid}, 32'd0);
        chk("R1 res_class", {27'd0, res_class}, 32'd0);
        chk("R1 res_drop",  {31'd0, res_drop},  32'd0);
        for (int i = 0; i < 8; i++) begin
            rd_chk(2'd0, 3'(i), 32'd0, "R1 word");
            rd_chk(2'd1, 3'(i), 32'd0, "R1 ctrl");
        end
        rd_chk(2'd2, 3'd0, 32'd0, "R1 cfg");
    endtask

    task automatic t_regs;
        wr(2'd2, 3'd0, 32'hFFFF_FFFF);
        rd_chk(2'd2, 3'd0, 32'h0000_00F8, "R2 cfg keeps 7:3");
        wr(2'd1, 3'd7, 32'hFFFF_FFFF);
        rd_chk(2'd1, 3'd7, 32'h8400_000F, "R2 ctrl keeps 31,26,3:0");
        wr(2'd0, 3'd6, 32'hDEAD_BEEF);
        rd_chk(2'd0, 3'd6, 32'hDEAD_BEEF, "R2 word full width");
        rd_chk(2'd1, 3'd6, 32'd0, "R2 word write leaves ctrl");
        wr(2'd1, 3'd7, 32'd0);
        wr(2'd2, 3'd0, 32'h0000_0048);   // default class 9
        rd_chk(2'd2, 3'd0, 32'h0000_0048, "R2 cfg default 9");
    endtask

    task automatic t_masked;
        wr(2'd0, 3'd0, 32'h00F0_1234);
        wr(2'd1, 3'd0, 32'h8000_0002);   // enabled, masked, code 2 -> class 3
        all_ops(32'hABCD_12F4);
        classify(5'd3, 1'b0, "R3 masked bits 7:4 ignored, upper half ignored");
        all_ops(32'h0000_1334);
        classify(5'd9, 1'b0, "R7 masked miss gives default");
        wr(2'd1, 3'd0, 32'd0);
    endtask

    task automatic t_full;
        wr(2'd0, 3'd1, 32'hCAFE_0055);
        wr(2'd1, 3'd1, 32'h8400_0005);   // enabled, full, class 6
        all_ops(32'hCAFE_0055);
        classify(5'd6, 1'b0, "R4 full exact hit");
        all_ops(32'hCAFF_0055);
        classify(5'd9, 1'b0, "R4 full upper mismatch misses");
        wr(2'd1, 3'd1, 32'h8000_0005);   // same word, masked mode
        classify(5'd6, 1'b0, "R3 masked mode ignores operand upper half");
        wr(2'd1, 3'd1, 32'd0);
    endtask

    task automatic t_disabled;
        wr(2'd0, 3'd3, 32'h0000_0077);
        wr(2'd1, 3'd3, 32'h0000_0006);   // enable clear
        all_ops(32'h0000_0077);
        classify(5'd9, 1'b0, "R5 disabled rule never hits");
        wr(2'd1, 3'd3, 32'h8000_0006);
        classify(5'd7, 1'b0, "R5 same rule enabled hits");
        wr(2'd1, 3'd3, 32'd0);
    endtask

    task automatic t_priority;
        wr(2'd0, 3'd2, 32'h0000_0011);
        wr(2'd1, 3'd2, 32'h8000_000A);   // class 11
        wr(2'd0, 3'd5, 32'h0000_0022);
        wr(2'd1, 3'd5, 32'h8000_0003);   // class 4
        all_ops(32'h0000_0000);
        op_data[2*32 +: 32] = 32'h0000_0011;
        op_data[5*32 +: 32] = 32'h0000_0022;
        classify(5'd11, 1'b0, "R6 lowest index wins");
        op_data[2*32 +: 32] = 32'h0000_0012;
        classify(5'd4, 1'b0, "R6 only higher rule hits");
        wr(2'd1, 3'd5, 32'h8000_000F);
        classify(5'd16, 1'b0, "R6 top code maps to class 16");
        wr(2'd1, 3'd2, 32'd0);
        wr(2'd1, 3'd5, 32'd0);
    endtask

    task automatic t_drop;
        wr(2'd2, 3'd0, 32'd0);
        all_ops(32'h1357_9BDF);
        classify(5'd0, 1'b1, "R8 zero default drops");
        wr(2'd2, 3'd0, 32'h0000_0080);   // default class 16
        classify(5'd16, 1'b0, "R7 default class 16 kept");
    endtask

    task automatic t_pulse;
        wr(2'd0, 3'd4, 32'h0000_00AA);
        wr(2'd1, 3'd4, 32'h8000_0000);   // class 1
        all_ops(32'h0000_00AA);
        @(negedge clk);
        op_valid = 1'b1;
        @(negedge clk);
        chk("R9 first of back-to-back valid", {31'd0, res_valid}, 32'd1);
        chk("R9 first of back-to-back class", {27'd0, res_class}, 32'd1);
        all_ops(32'h0000_00AB);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R9 second of back-to-back valid", {31'd0, res_valid}, 32'd1);
        chk("R9 second of back-to-back class", {27'd0, res_class}, 32'd16);
        @(negedge clk);
        chk("R9 idle valid low", {31'd0, res_valid}, 32'd0);
        chk("R9 idle class zero", {27'd0, res_class}, 32'd0);
        chk("R9 idle drop zero", {31'd0, res_drop}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_masked();
        t_full();
        t_disabled();
        t_priority();
        t_drop();
        t_pulse();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule